// File: doc/BRIEF.md
# Serial Receive Queue with Status Mode

This block is the receive side of one serial channel. A receiver core hands it finished characters, each with a valid strobe, eight data bits and four error flags (break, framing, overrun, parity). The block keeps them in a deep receive queue and shows the host two things. One is a read port that pops characters. The other is a 16-bit channel status word that holds sticky receive events and live line and transmitter conditions.

The host chooses one of two read formats. With status mode on, each word read gives one data byte together with that byte's own error bits. With status mode off, each word read gives two data bytes at once. A two-bit trigger select compares the queue occupancy with a threshold and raises a trigger flag. That flag is passed to the interrupt output only while the receive interrupt enable is set. A clear-count command empties the queue.

Occupancy is tracked by a state machine with three states. `OCC_EMPTY` holds no characters, `OCC_PART` holds between one and DEPTH-1, and `OCC_FULL` holds DEPTH. Its transitions are FILL_START (`OCC_EMPTY`→`OCC_PART`), FILL_TOP (`OCC_PART`→`OCC_FULL`, or `OCC_EMPTY`→`OCC_FULL` when DEPTH is 1), DRAIN_TOP (`OCC_FULL`→`OCC_PART`), DRAIN_OUT (`OCC_PART`→`OCC_EMPTY`, or `OCC_FULL`→`OCC_EMPTY`) and FLUSH (any state→`OCC_EMPTY` on clear-count).

Top module: `serial_rx_queue`

## Requirements
- R1: The queue holds up to DEPTH characters (default 1023), and `rx_count` reports how many are stored.
- R2: A character that arrives while `rx_count` equals DEPTH is dropped. The stored contents stay as they were, and sticky overflow bit 13 of `stat_word` is set.
- R3: `stat_word` bit 15 follows `stat_mode_en`, and bit 14 reads 0. The sticky event bits are set as follows: bit 12 by `cmp2_hit`, bit 11 by `cmp1_hit`, and bits 10, 9 and 8 by a valid character that carries break, framing error or parity error respectively.
- R4: A full status read (`stat_rd` with `stat_rd_byte` low) clears bits 13 to 8 at the next edge. A low-byte-only read (`stat_rd` with `stat_rd_byte` high) leaves them unchanged. A new event in the same cycle takes priority over the clear.
- R5: The `stat_word` low byte has bits 7 and 6 at 0. Bit 5 is CTS, bit 4 DSR, bit 3 CD, bit 2 transmit queue empty and bit 1 transmit shifter empty. Bit 0 is 1 whenever the queue holds at least one character.
- R6: With status mode on, `rd_data` holds the oldest byte in bits 7:0 and its error flags in bits 11:8 (break at bit 11, framing at bit 10, overrun at bit 9, parity at bit 8). Bits 15:12 are 0. A `rd_word` pulse pops one character.
- R7: With status mode off and at least two characters stored, `rd_data` holds the oldest byte in bits 7:0 and the next byte in bits 15:8. A `rd_word` pulse pops both.
- R8: With status mode off and exactly one character stored, `rd_data` holds that byte in bits 7:0 with bits 15:8 at 0. A `rd_word` pulse pops only that one.
- R9: `trig_sel` selects the trigger threshold: 00 never triggers, 01 triggers at 1 or more, 10 at (DEPTH+1)/2 or more, and 11 at 7·(DEPTH+1)/8 or more. With the default depth these are 512 and 896. `trig_flag` shows the result whatever `rx_irq_en` is set to.
- R10: `rx_irq` is high exactly when `trig_flag` is high and `rx_irq_en` is set.
- R11: A `cnt_clear` pulse empties the queue and clears overflow bit 13. A character arriving in the same cycle is discarded.
- R12: After reset the queue is empty, `rx_count` is 0, all sticky bits are 0 and `rd_data` is 0.
- R13: While the queue is empty, `rd_data` reads 0 and a `rd_word` pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Character-valid strobe from receiver core |
| rx_data | input | 8 | Received data byte |
| rx_brk | input | 1 | Break detected with this character |
| rx_frm | input | 1 | Framing error with this character |
| rx_ovr | input | 1 | Receiver overrun with this character |
| rx_par | input | 1 | Parity error with this character |
| cmp1_hit | input | 1 | First compare-byte match event |
| cmp2_hit | input | 1 | Second compare-byte match event |
| cts_in | input | 1 | CTS line level |
| dsr_in | input | 1 | DSR line level |
| cd_in | input | 1 | CD line level |
| txf_empty | input | 1 | Transmit queue empty |
| txs_empty | input | 1 | Transmit shifter empty |
| stat_mode_en | input | 1 | Status mode select for word reads |
| trig_sel | input | 2 | Trigger threshold select |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_word | input | 1 | Host word-read strobe (pops at clock edge) |
| rd_data | output | 16 | Word presented for the next read |
| stat_rd | input | 1 | Host status-read strobe |
| stat_rd_byte | input | 1 | Status read covers only the low byte |
| stat_word | output | 16 | Channel status word |
| cnt_clear | input | 1 | Clear-count command (empties queue) |
| rx_count | output | 10 | Current occupancy |
| trig_flag | output | 1 | Trigger threshold reached |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
`rd_data` is combinational from the head of the queue, so it is valid in the same cycle as its read and changes only after the edge that pops. Everything else is due one edge after the stimulus: `rx_count`, the sticky bits 13 to 8, and `trig_flag`/`rx_irq`, which are derived from the registered count. The live low-byte bits and bit 15 follow their inputs without a register. The bench drives every input just after a falling edge and samples every output at the next falling edge. It reads `rd_data` before issuing the pop and reads the count and flags after it. This places each check half a cycle away from the edge that produced its value.

// File: rtl/srq_pkg.sv
package srq_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       ovr;
        logic       par;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/srq_store.sv
module srq_store
    import srq_pkg::*;
#(
    parameter int DEPTH = 1023,
    parameter int PTR_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  rx_char_t   wr_char,
    input  logic [1:0] pop_n,
    output rx_char_t   head0,
    output rx_char_t   head1
);

    localparam logic [PTR_W:0] WRAP = (PTR_W+1)'(DEPTH);

    rx_char_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] rd_ptr_nx1;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                             input logic [1:0] n);
        logic [PTR_W:0] s;
        s = {1'b0, p} + (PTR_W+1)'(n);
        if (s >= WRAP) s = s - WRAP;
        return s[PTR_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_char;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= adv(wr_ptr, 2'd1);
            rd_ptr <= adv(rd_ptr, pop_n);
        end
    end

    always_comb begin
        rd_ptr_nx1 = adv(rd_ptr, 2'd1);
        head0      = mem[rd_ptr];
        head1      = mem[rd_ptr_nx1];
    end

endmodule

// File: rtl/srq_level.sv
module srq_level
    import srq_pkg::*;
#(
    parameter int DEPTH = 1023,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [1:0]       pop_n,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    occ_state_t       state, state_nxt;
    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        count_nxt = count + CNT_W'(push) - CNT_W'(pop_n);
        state_nxt = state;
        if (flush) begin
            state_nxt = OCC_EMPTY;                              // FLUSH
        end else begin
            unique case (state)
                OCC_EMPTY: begin
                    if (count_nxt == TOP)     state_nxt = OCC_FULL;  // FILL_TOP
                    else if (count_nxt != '0) state_nxt = OCC_PART;  // FILL_START
                end
                OCC_PART: begin
                    if (count_nxt == '0)       state_nxt = OCC_EMPTY; // DRAIN_OUT
                    else if (count_nxt == TOP) state_nxt = OCC_FULL;  // FILL_TOP
                end
                OCC_FULL: begin
                    if (count_nxt == '0)       state_nxt = OCC_EMPTY; // DRAIN_OUT
                    else if (count_nxt != TOP) state_nxt = OCC_PART;  // DRAIN_TOP
                end
                default: state_nxt = OCC_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= flush ? '0 : count_nxt;
        end
    end

    always_comb begin
        is_empty = (state == OCC_EMPTY);
        is_full  = (state == OCC_FULL);
    end

endmodule

// File: rtl/srq_flags.sv
module srq_flags #(
    parameter int NFLAG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic             clr_all,
    input  logic             clr_top,
    output logic [NFLAG-1:0] flags
);

    logic [NFLAG-1:0] keep_mask;

    always_comb begin
        keep_mask = ~{(clr_all | clr_top), {(NFLAG-1){clr_all}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & keep_mask) | set_vec;
    end

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import srq_pkg::*;
#(
    parameter int DEPTH = 1023,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_brk,
    input  logic             rx_frm,
    input  logic             rx_ovr,
    input  logic             rx_par,
    input  logic             cmp1_hit,
    input  logic             cmp2_hit,
    input  logic             cts_in,
    input  logic             dsr_in,
    input  logic             cd_in,
    input  logic             txf_empty,
    input  logic             txs_empty,
    input  logic             stat_mode_en,
    input  logic [1:0]       trig_sel,
    input  logic             rx_irq_en,
    input  logic             rd_word,
    output logic [15:0]      rd_data,
    input  logic             stat_rd,
    input  logic             stat_rd_byte,
    output logic [15:0]      stat_word,
    input  logic             cnt_clear,
    output logic [CNT_W-1:0] rx_count,
    output logic             trig_flag,
    output logic             rx_irq
);

    localparam logic [CNT_W-1:0] LVL_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LVL_TWO  = CNT_W'(2);
    localparam logic [CNT_W-1:0] LVL_HALF = CNT_W'((DEPTH + 1) / 2);
    localparam logic [CNT_W-1:0] LVL_7_8  = CNT_W'(((DEPTH + 1) * 7) / 8);

    rx_char_t   in_char, head0, head1;
    logic       push_ok, ovf_evt, lvl_empty, lvl_full;
    logic [1:0] pop_n;
    logic [5:0] set_vec, sticky;

    always_comb begin
        in_char = '{brk: rx_brk, frm: rx_frm, ovr: rx_ovr, par: rx_par, data: rx_data};
        push_ok = rx_valid && !cnt_clear && !lvl_full;
        ovf_evt = rx_valid && !cnt_clear && lvl_full;
        pop_n   = 2'd0;
        if (rd_word && !cnt_clear && !lvl_empty) begin
            if (stat_mode_en || (rx_count < LVL_TWO)) pop_n = 2'd1;
            else                                      pop_n = 2'd2;
        end
        set_vec = {ovf_evt, cmp2_hit, cmp1_hit,
                   rx_valid & rx_brk, rx_valid & rx_frm, rx_valid & rx_par};
    end

    srq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cnt_clear),
        .push    (push_ok),
        .wr_char (in_char),
        .pop_n   (pop_n),
        .head0   (head0),
        .head1   (head1)
    );

    srq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cnt_clear),
        .push     (push_ok),
        .pop_n    (pop_n),
        .count    (rx_count),
        .is_empty (lvl_empty),
        .is_full  (lvl_full)
    );

    srq_flags #(.NFLAG(6)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_all (stat_rd & ~stat_rd_byte),
        .clr_top (cnt_clear),
        .flags   (sticky)
    );

    always_comb begin
        if (lvl_empty)
            rd_data = 16'h0000;
        else if (stat_mode_en)
            rd_data = {4'h0, head0.brk, head0.frm, head0.ovr, head0.par, head0.data};
        else if (rx_count >= LVL_TWO)
            rd_data = {head1.data, head0.data};
        else
            rd_data = {8'h00, head0.data};

        stat_word = {stat_mode_en, 1'b0, sticky, 2'b00,
                     cts_in, dsr_in, cd_in, txf_empty, txs_empty, !lvl_empty};

        unique case (trig_sel)
            2'b00:   trig_flag = 1'b0;
            2'b01:   trig_flag = (rx_count >= LVL_ONE);
            2'b10:   trig_flag = (rx_count >= LVL_HALF);
            default: trig_flag = (rx_count >= LVL_7_8);
        endcase
        rx_irq = trig_flag & rx_irq_en;
    end

endmodule

// File: rtl/srq_chk.sv
module srq_chk #(
    parameter int DEPTH = 1023,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             cmp1_hit,
    input logic             cmp2_hit,
    input logic             stat_mode_en,
    input logic             rd_word,
    input logic             stat_rd,
    input logic             stat_rd_byte,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] rx_count,
    input logic [15:0]      stat_word
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= TOP);

    // R2
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_count == TOP && !cnt_clear) |=> stat_word[13]);

    // R4
    full_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_rd_byte && !rx_valid && !cmp1_hit && !cmp2_hit)
        |=> (stat_word[13:8] == 6'b0));

    // R6
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && stat_mode_en && rx_count != '0 && !rx_valid && !cnt_clear)
        |=> (rx_count == $past(rx_count) - CNT_W'(1)));

    // R11
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (rx_count == '0 && !stat_word[13]));

endmodule

bind serial_rx_queue srq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_srq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .cmp1_hit     (cmp1_hit),
    .cmp2_hit     (cmp2_hit),
    .stat_mode_en (stat_mode_en),
    .rd_word      (rd_word),
    .stat_rd      (stat_rd),
    .stat_rd_byte (stat_rd_byte),
    .cnt_clear    (cnt_clear),
    .rx_count     (rx_count),
    .stat_word    (stat_word)
);

// File: tb/test_serial_rx_queue.sv
`timescale 1ns/1ps
module test_serial_rx_queue;

    localparam int DEPTH = 1023;
    localparam int CNT_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_brk = 0, rx_frm = 0, rx_ovr = 0, rx_par = 0;
    logic [7:0] rx_data = 8'h00;
    logic cmp1_hit = 0, cmp2_hit = 0;
    logic cts_in = 0, dsr_in = 0, cd_in = 0, txf_empty = 0, txs_empty = 0;
    logic stat_mode_en = 0, rx_irq_en = 0, rd_word = 0;
    logic [1:0] trig_sel = 2'b00;
    logic stat_rd = 0, stat_rd_byte = 0, cnt_clear = 0;
    logic [15:0] rd_data, stat_word;
    logic [CNT_W-1:0] rx_count;
    logic trig_flag, rx_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int seq = 0;

    always #2.5 clk = ~clk;

    serial_rx_queue #(.DEPTH(DEPTH)) i_serial_rx_queue (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_ovr(rx_ovr), .rx_par(rx_par),
        .cmp1_hit(cmp1_hit), .cmp2_hit(cmp2_hit), .cts_in(cts_in),
        .dsr_in(dsr_in), .cd_in(cd_in), .txf_empty(txf_empty),
        .txs_empty(txs_empty), .stat_mode_en(stat_mode_en),
        .trig_sel(trig_sel), .rx_irq_en(rx_irq_en), .rd_word(rd_word),
        .rd_data(rd_data), .stat_rd(stat_rd), .stat_rd_byte(stat_rd_byte),
        .stat_word(stat_word), .cnt_clear(cnt_clear), .rx_count(rx_count),
        .trig_flag(trig_flag), .rx_irq(rx_irq)
    );

    // {cts, dsr, cd, txf_empty, txs_empty} stimulus, expected low byte (queue empty)
    localparam logic [12:0] LOW_TAB [8] = '{
        {5'b10000, 8'h20}, {5'b01000, 8'h10}, {5'b00100, 8'h08},
        {5'b00010, 8'h04}, {5'b00001, 8'h02}, {5'b11111, 8'h3E},
        {5'b10101, 8'h2A}, {5'b00000, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [3:0] err);
        rx_valid = 1; rx_data = d;
        {rx_brk, rx_frm, rx_ovr, rx_par} = err;
        tick();
        rx_valid = 0; {rx_brk, rx_frm, rx_ovr, rx_par} = 4'h0;
    endtask

    task automatic pop();
        rd_word = 1; tick(); rd_word = 0;
    endtask

    task automatic fill_to(input int n);
        while (int'(rx_count) < n) begin
            push(8'(seq), 4'h0);
            seq++;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R12 reset state
        check("R12 count", 16'(rx_count), 16'h0);
        check("R12 stat", stat_word, 16'h0000);
        check("R12 rd_data", rd_data, 16'h0000);

        // R5 table of line inputs
        for (int i = 0; i < 8; i++) begin
            {cts_in, dsr_in, cd_in, txf_empty, txs_empty} = LOW_TAB[i][12:8];
            @(negedge clk);
            check("R5 low byte", stat_word, {8'h00, LOW_TAB[i][7:0]});
        end

        // R6 / R3 status mode
        stat_mode_en = 1;
        push(8'h41, 4'b1000);
        push(8'h42, 4'b0010);
        push(8'h43, 4'b0101);
        check("R1 count3", 16'(rx_count), 16'd3);
        check("R3 events", stat_word, 16'h8701);
        cmp1_hit = 1; cmp2_hit = 1; tick(); cmp1_hit = 0; cmp2_hit = 0;
        check("R3 cmp", stat_word, 16'h9F01);
        stat_rd = 1; stat_rd_byte = 1; tick(); stat_rd = 0; stat_rd_byte = 0;
        check("R4 byte read keeps", stat_word, 16'h9F01);
        stat_rd = 1; tick(); stat_rd = 0;
        check("R4 full read clears", stat_word, 16'h8001);
        check("R6 word1", rd_data, 16'h0841);
        pop();
        check("R6 pop1", 16'(rx_count), 16'd2);
        check("R6 word2", rd_data, 16'h0242);
        pop();
        check("R6 word3", rd_data, 16'h0543);
        pop();
        check("R6 drained", 16'(rx_count), 16'd0);
        check("R5 rda off", stat_word, 16'h8000);

        // R7 / R8 / R13 paired mode
        stat_mode_en = 0;
        push(8'h11, 4'h0); push(8'h22, 4'h4); push(8'h33, 4'h0);
        check("R7 pair", rd_data, 16'h2211);
        pop();
        check("R7 pop2", 16'(rx_count), 16'd1);
        check("R8 single", rd_data, 16'h0033);
        pop();
        check("R8 pop1", 16'(rx_count), 16'd0);
        check("R13 empty data", rd_data, 16'h0000);
        pop();
        check("R13 empty pop", 16'(rx_count), 16'd0);

        // R9 / R10 trigger
        stat_rd = 1; tick(); stat_rd = 0;
        push(8'(seq), 4'h0); seq++;
        check("R9 sel00", 16'(trig_flag), 16'd0);
        trig_sel = 2'b01; @(negedge clk);
        check("R9 sel01", 16'(trig_flag), 16'd1);
        check("R10 gated", 16'(rx_irq), 16'd0);
        rx_irq_en = 1; @(negedge clk);
        check("R10 enabled", 16'(rx_irq), 16'd1);
        trig_sel = 2'b10;
        fill_to(511);
        check("R9 half-1", 16'(trig_flag), 16'd0);
        fill_to(512);
        check("R9 half", 16'(trig_flag), 16'd1);
        trig_sel = 2'b11;
        fill_to(895);
        check("R9 7/8-1", 16'(trig_flag), 16'd0);
        fill_to(896);
        check("R9 7/8", 16'(trig_flag), 16'd1);
        check("R10 irq 7/8", 16'(rx_irq), 16'd1);

        // R1 / R2 full and overflow
        fill_to(DEPTH);
        check("R1 full count", 16'(rx_count), 16'(DEPTH));
        check("R2 no ovf yet", 16'(stat_word[13]), 16'd0);
        push(8'hEE, 4'h0);
        check("R2 dropped", 16'(rx_count), 16'(DEPTH));
        check("R2 ovf bit", 16'(stat_word[13]), 16'd1);
        check("R2 head intact", rd_data, 16'h0100);

        // R11 clear-count with concurrent character
        cnt_clear = 1; rx_valid = 1; rx_data = 8'h77;
        tick();
        cnt_clear = 0; rx_valid = 0;
        check("R11 count", 16'(rx_count), 16'd0);
        check("R11 ovf clear", 16'(stat_word[13]), 16'd0);
        check("R11 trig", 16'(trig_flag), 16'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule